// File: doc/BRIEF.md
# Register Write Guard

This block sits between a serial host port and a register file. It inspects each finished host write before anything reaches storage. A write is committed only if the target register is writable, the byte count matches that register's width, no reserved bit is set, and, for the command register, the opcode is one the device understands. The block also inspects each byte the host reads, and flags reads that run past the end of a register or that target an address with nothing readable behind it.

Every violation is reported the same way, through two sticky flags. The interface-error flag sits at bit 0 of the fault status register, and the fault summary sits at bit 9 of the alert register. Each flag stays set until the host clears it by writing a one to it. One cycle after a transaction ends, the block presents an accept or reject verdict. When it accepts a write, it also presents a commit strobe with the address and data. The block keeps only the two flags and a copy of the last accepted command opcode. All other register contents belong to the register file.

Top module: `reg_write_guard`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every output is zero.
- R2: A transaction whose total length (address byte included) is 1 or less only sets up the read pointer. One cycle later `resValid` and `resAccept` are 1, `commitEn` is 0, and neither fault flag changes.
- R3: Some registers are 2 bytes wide: 0x00, 0x02 and 0x04 (identity and revision), 0x10 (alert), 0x12 (alert mask), 0x20 and 0x22 (capability), 0x28 (timer), 0x70 (bus voltage), and 0x72, 0x74, 0x76 and 0x78 (voltage thresholds). Writing one of them needs a total length of 3. Every other register is 1 byte wide and needs a total length of 2. Any other length is rejected.
- R4: A write that sets a reserved bit is rejected. The reserved bits are 0x80 at 0x19 (role control), 0x80 at 0x1A (fault control), and 0xFC in the upper byte (mask 0xFC00) at 0x72, 0x74, 0x76 and 0x78.
- R5: A write to a read-only address is rejected. The read-only addresses are 0x00, 0x02, 0x04, 0x20, 0x22, 0x70, 0x1C and 0x1D. A write to any address outside the map is rejected too, including the upper byte of a 2-byte register such as 0x11.
- R6: A rejected write gives `resValid`=1, `resAccept`=0 and `commitEn`=0 one cycle after `txnDone`. In that same cycle `ifErr` and `alertFault` become 1, and both stay 1 until cleared.
- R7: An accepted write gives `resValid`, `resAccept` and `commitEn` all equal to 1 one cycle after `txnDone`. It also presents the address on `commitAddr`. The data appears on `commitData`, with the upper byte forced to zero for a 1-byte register, and `commitWide` equals the register width minus 1.
- R8: A write to the command register (0x23) must carry exactly one data byte. Its opcode must be one of 0x11, 0x22, 0x33, 0x44, 0x55, 0x66, 0x77, 0x88 or 0x99. A valid opcode appears on `cmdLast`. Anything else is rejected, and `cmdLast` keeps its value.
- R9: A read strobe with byte index 2 or more on a 2-byte register, or byte index 1 or more on a 1-byte register, sets `ifErr` and `alertFault` one cycle later.
- R10: A read strobe at the write-only command register or at an undefined address sets both fault flags one cycle later.
- R11: An accepted write to fault status (0x1E) with bit 0 set clears `ifErr`, and an accepted write to alert (0x10) with bit 9 set clears `alertFault`. Writes with those bits at zero leave the flags alone. If a fault is raised in the same cycle as a clear, the fault wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txnDone | input | 1 | One-cycle pulse: a host write transaction has finished |
| txnAddr | input | 8 | Register address of the finished write |
| txnLen | input | LEN_W | Bytes in the transaction, address byte included |
| txnData | input | 16 | First data byte in [7:0], second in [15:8] |
| rdValid | input | 1 | One-cycle pulse: the host is reading one byte |
| rdAddr | input | 8 | Register address of the read |
| rdIndex | input | IDX_W | Byte index of the read within the register |
| resValid | output | 1 | Verdict valid for this cycle |
| resAccept | output | 1 | Verdict: 1 accepted, 0 rejected |
| commitEn | output | 1 | Commit the write to the register file |
| commitAddr | output | 8 | Address to commit |
| commitData | output | 16 | Data to commit |
| commitWide | output | 1 | Committed register is 2 bytes wide |
| ifErr | output | 1 | Interface-error flag (fault status bit 0) |
| alertFault | output | 1 | Fault summary flag (alert bit 9) |
| cmdLast | output | 8 | Last accepted command opcode |

## Verification
The bench targets the edges of the reserved masks. A threshold upper byte of 0x03 must pass while 0x04 fails, and 0x7F must pass at fault control while 0x80 fails. A design with an off-by-one mask would commit a forbidden bit or refuse a legal value. It also feeds a 1-byte register a value with garbage in the second data byte; a design that does not zero that byte would commit the garbage. Other cases include:
- a command write with a valid opcode but two data bytes, which a check that looks only at the opcode would wrongly accept;
- write-one-to-clear writes with the wrong bit, which a design that clears on any write to the register would act on;
- reads exactly one byte past the register's end, where a width lookup that is off by one would either miss the fault or raise it on a legal read.

// File: rtl/reg_write_guard_pkg.sv
package reg_write_guard_pkg;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] ADR_ALERT      = 8'h10;
  localparam logic [ADDR_W-1:0] ADR_FAULT_STAT = 8'h1E;
  localparam logic [ADDR_W-1:0] ADR_COMMAND    = 8'h23;

  localparam int IFERR_BIT       = 0;
  localparam int ALERT_FAULT_BIT = 9;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_RO,
    ACC_RW,
    ACC_W1C,
    ACC_CMD
  } accKind_e;

  typedef struct packed {
    accKind_e          kind;
    logic              wide;
    logic [DATA_W-1:0] rsvd;
  } regInfo_t;

  typedef struct packed {
    logic resValid;
    logic resAccept;
    logic commit;
    logic cmdLoad;
    logic setFault;
    logic clrIfErr;
    logic clrAlert;
  } strobes_t;

  // Width, access kind and reserved mask for every mapped address.
  function automatic regInfo_t lookupReg(input logic [ADDR_W-1:0] a);
    regInfo_t r;
    r.kind = ACC_NONE;
    r.wide = 1'b0;
    r.rsvd = '0;
    case (a)
      8'h00, 8'h02, 8'h04,
      8'h20, 8'h22, 8'h70: begin
        r.kind = ACC_RO;
        r.wide = 1'b1;
      end
      8'h10: begin
        r.kind = ACC_W1C;
        r.wide = 1'b1;
      end
      8'h12, 8'h28: begin
        r.kind = ACC_RW;
        r.wide = 1'b1;
      end
      8'h72, 8'h74, 8'h76, 8'h78: begin
        r.kind = ACC_RW;
        r.wide = 1'b1;
        r.rsvd = 16'hFC00;
      end
      8'h14, 8'h15, 8'h18, 8'h1B: r.kind = ACC_RW;
      8'h19, 8'h1A: begin
        r.kind = ACC_RW;
        r.rsvd = 16'h0080;
      end
      8'h1C, 8'h1D: r.kind = ACC_RO;
      8'h1E:        r.kind = ACC_W1C;
      8'h23:        r.kind = ACC_CMD;
      default:      r.kind = ACC_NONE;
    endcase
    return r;
  endfunction

  function automatic logic knownOpcode(input logic [7:0] op);
    logic ok;
    case (op)
      8'h11, 8'h22, 8'h33, 8'h44, 8'h55,
      8'h66, 8'h77, 8'h88, 8'h99: ok = 1'b1;
      default:                    ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/reg_write_guard_ctrl.sv
module reg_write_guard_ctrl
  import reg_write_guard_pkg::*;
#(
  parameter int LEN_W = 4,
  parameter int IDX_W = 4
) (
  input  logic              txnDone,
  input  logic [ADDR_W-1:0] txnAddr,
  input  logic [LEN_W-1:0]  txnLen,
  input  logic [DATA_W-1:0] txnData,
  input  logic              rdValid,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [IDX_W-1:0]  rdIndex,
  output strobes_t          stb,
  output logic              wrWide
);

  localparam logic [LEN_W-1:0] LEN_PTR    = LEN_W'(1);
  localparam logic [LEN_W-1:0] LEN_NARROW = LEN_W'(2);
  localparam logic [LEN_W-1:0] LEN_WIDE   = LEN_W'(3);
  localparam logic [IDX_W-1:0] IDX_NARROW = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_WIDE   = IDX_W'(2);

  regInfo_t wrInfo;
  regInfo_t rdInfo;
  logic     pointerOnly;
  logic     widthOk;
  logic     rsvdOk;
  logic     accessOk;
  logic     opcodeOk;
  logic     wrGood;
  logic     wrReject;
  logic     wrCommit;
  logic     rdBad;

  // write-side checks
  always_comb begin
    wrInfo      = lookupReg(txnAddr);
    pointerOnly = (txnLen <= LEN_PTR);
    widthOk     = (txnLen == (wrInfo.wide ? LEN_WIDE : LEN_NARROW));
    rsvdOk      = ((txnData & wrInfo.rsvd) == '0);
    accessOk    = (wrInfo.kind == ACC_RW) || (wrInfo.kind == ACC_W1C) ||
                  (wrInfo.kind == ACC_CMD);
    opcodeOk    = (wrInfo.kind != ACC_CMD) || knownOpcode(txnData[7:0]);
    wrGood      = widthOk && rsvdOk && accessOk && opcodeOk;
    wrReject    = txnDone && !pointerOnly && !wrGood;
    wrCommit    = txnDone && !pointerOnly && wrGood;
    wrWide      = wrInfo.wide;
  end

  // read-side checks
  always_comb begin
    rdInfo = lookupReg(rdAddr);
    rdBad  = rdValid &&
             ((rdInfo.kind == ACC_NONE) || (rdInfo.kind == ACC_CMD) ||
              (rdIndex >= (rdInfo.wide ? IDX_WIDE : IDX_NARROW)));
  end

  always_comb begin
    stb.resValid  = txnDone;
    stb.resAccept = txnDone && !wrReject;
    stb.commit    = wrCommit;
    stb.cmdLoad   = wrCommit && (txnAddr == ADR_COMMAND);
    stb.setFault  = wrReject || rdBad;
    stb.clrIfErr  = wrCommit && (txnAddr == ADR_FAULT_STAT) && txnData[IFERR_BIT];
    stb.clrAlert  = wrCommit && (txnAddr == ADR_ALERT) && txnData[ALERT_FAULT_BIT];
  end

endmodule

// File: rtl/reg_write_guard_dp.sv
module reg_write_guard_dp
  import reg_write_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic              wrWide,
  input  logic [ADDR_W-1:0] txnAddr,
  input  logic [DATA_W-1:0] txnData,
  output logic              resValid,
  output logic              resAccept,
  output logic              commitEn,
  output logic [ADDR_W-1:0] commitAddr,
  output logic [DATA_W-1:0] commitData,
  output logic              commitWide,
  output logic              ifErr,
  output logic              alertFault,
  output logic [7:0]        cmdLast
);

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] shapedData;

  always_comb begin
    shapedData = wrWide ? txnData : {{HALF_W{1'b0}}, txnData[HALF_W-1:0]};
  end

  // verdict and commit path
  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid   <= 1'b0;
      resAccept  <= 1'b0;
      commitEn   <= 1'b0;
      commitAddr <= '0;
      commitData <= '0;
      commitWide <= 1'b0;
    end else begin
      resValid  <= stb.resValid;
      resAccept <= stb.resAccept;
      commitEn  <= stb.commit;
      if (stb.commit) begin
        commitAddr <= txnAddr;
        commitData <= shapedData;
        commitWide <= wrWide;
      end
    end
  end

  // sticky fault flags; raising beats clearing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ifErr      <= 1'b0;
      alertFault <= 1'b0;
    end else begin
      if (stb.setFault)      ifErr <= 1'b1;
      else if (stb.clrIfErr) ifErr <= 1'b0;
      if (stb.setFault)      alertFault <= 1'b1;
      else if (stb.clrAlert) alertFault <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           cmdLast <= '0;
    else if (stb.cmdLoad) cmdLast <= txnData[7:0];
  end

endmodule

// File: rtl/reg_write_guard.sv
module reg_write_guard
  import reg_write_guard_pkg::*;
#(
  parameter int LEN_W = 4,
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txnDone,
  input  logic [7:0]        txnAddr,
  input  logic [LEN_W-1:0]  txnLen,
  input  logic [15:0]       txnData,
  input  logic              rdValid,
  input  logic [7:0]        rdAddr,
  input  logic [IDX_W-1:0]  rdIndex,
  output logic              resValid,
  output logic              resAccept,
  output logic              commitEn,
  output logic [7:0]        commitAddr,
  output logic [15:0]       commitData,
  output logic              commitWide,
  output logic              ifErr,
  output logic              alertFault,
  output logic [7:0]        cmdLast
);

  strobes_t stb;
  logic     wrWide;

  reg_write_guard_ctrl #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_ctrl (
    .txnDone (txnDone),
    .txnAddr (txnAddr),
    .txnLen  (txnLen),
    .txnData (txnData),
    .rdValid (rdValid),
    .rdAddr  (rdAddr),
    .rdIndex (rdIndex),
    .stb     (stb),
    .wrWide  (wrWide)
  );

  reg_write_guard_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrWide     (wrWide),
    .txnAddr    (txnAddr),
    .txnData    (txnData),
    .resValid   (resValid),
    .resAccept  (resAccept),
    .commitEn   (commitEn),
    .commitAddr (commitAddr),
    .commitData (commitData),
    .commitWide (commitWide),
    .ifErr      (ifErr),
    .alertFault (alertFault),
    .cmdLast    (cmdLast)
  );

endmodule

// File: rtl/reg_write_guard_props.sv
module reg_write_guard_props #(
  parameter int LEN_W = 4,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             txnDone,
  input logic [LEN_W-1:0] txnLen,
  input logic             rdValid,
  input logic [IDX_W-1:0] rdIndex,
  input logic             resValid,
  input logic             resAccept,
  input logic             commitEn,
  input logic [7:0]       commitAddr,
  input logic             ifErr,
  input logic             alertFault,
  input logic [7:0]       cmdLast
);

  // R7
  commit_needs_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitEn |-> (resValid && resAccept));

  // R7
  verdict_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(txnDone));

  // R2
  pointer_no_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txnDone && (txnLen <= LEN_W'(1))) |=> (resValid && resAccept && !commitEn));

  // R6
  reject_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resAccept) |-> (ifErr && alertFault && !commitEn));

  // R9
  read_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && (rdIndex >= IDX_W'(2))) |=> (ifErr && alertFault));

  // R8
  cmd_only_on_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cmdLast) |-> (commitEn && (commitAddr == 8'h23)));

  // R6
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ifErr) |-> $past(txnDone || rdValid));

endmodule

bind reg_write_guard reg_write_guard_props #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_props (.*);

// File: tb/reg_write_guard_bench.sv
module reg_write_guard_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        txnDone;
  logic [7:0]  txnAddr;
  logic [3:0]  txnLen;
  logic [15:0] txnData;
  logic        rdValid;
  logic [7:0]  rdAddr;
  logic [3:0]  rdIndex;
  logic        resValid;
  logic        resAccept;
  logic        commitEn;
  logic [7:0]  commitAddr;
  logic [15:0] commitData;
  logic        commitWide;
  logic        ifErr;
  logic        alertFault;
  logic [7:0]  cmdLast;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  reg_write_guard #(.LEN_W(4), .IDX_W(4)) u_reg_write_guard (.*);

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] l, input logic [15:0] d);
    @(negedge clk);
    txnDone = 1'b1; txnAddr = a; txnLen = l; txnData = d;
    @(negedge clk);
    txnDone = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [3:0] idx);
    @(negedge clk);
    rdValid = 1'b1; rdAddr = a; rdIndex = idx;
    @(negedge clk);
    rdValid = 1'b0;
  endtask

  task automatic clearFaults();
    wr(8'h1E, 4'd2, 16'h0001);
    wr(8'h10, 4'd3, 16'h0200);
    checkEq("R11 flags cleared", {ifErr, alertFault}, 2'b00);
  endtask

  task automatic expectReject(input string tag, input logic [7:0] a,
                              input logic [3:0] l, input logic [15:0] d);
    wr(a, l, d);
    checkEq({tag, " verdict"}, {resValid, resAccept, commitEn}, 3'b100);
    checkEq({tag, " R6 flags"}, {ifErr, alertFault}, 2'b11);
    clearFaults();
  endtask

  task automatic expectAccept(input string tag, input logic [7:0] a, input logic [3:0] l,
                              input logic [15:0] d, input logic [15:0] expData,
                              input logic expWide);
    wr(a, l, d);
    checkEq({tag, " R7 verdict"}, {resValid, resAccept, commitEn}, 3'b111);
    checkEq({tag, " R7 commit"}, {commitAddr, commitData, commitWide}, {a, expData, expWide});
    checkEq({tag, " no fault"}, {ifErr, alertFault}, 2'b00);
  endtask

  task automatic tReset();
    checkEq("R1 outputs zero",
            {resValid, resAccept, commitEn, commitAddr, commitData, commitWide,
             ifErr, alertFault, cmdLast}, '0);
  endtask

  task automatic tPointer();
    wr(8'h19, 4'd1, 16'h00FF);
    checkEq("R2 pointer setup", {resValid, resAccept, commitEn, ifErr, alertFault}, 5'b11000);
  endtask

  task automatic tAccepts();
    expectAccept("narrow", 8'h19, 4'd2, 16'h000A, 16'h000A, 1'b0);
    expectAccept("wide", 8'h72, 4'd3, 16'h038C, 16'h038C, 1'b1);
    expectAccept("narrow upper zeroed", 8'h14, 4'd2, 16'hAB55, 16'h0055, 1'b0);
    expectAccept("R4 rsvd edge thresh", 8'h78, 4'd3, 16'h03FF, 16'h03FF, 1'b1);
    expectAccept("R4 rsvd edge faultctl", 8'h1A, 4'd2, 16'h007F, 16'h007F, 1'b0);
  endtask

  task automatic tWidth();
    expectReject("R3 wide short", 8'h72, 4'd2, 16'h0001);
    expectReject("R3 narrow long", 8'h19, 4'd3, 16'h0001);
    expectReject("R3 alert mask short", 8'h12, 4'd2, 16'h0001);
  endtask

  task automatic tReserved();
    expectReject("R4 role ctl", 8'h19, 4'd2, 16'h0080);
    expectReject("R4 fault ctl", 8'h1A, 4'd2, 16'h0080);
    expectReject("R4 thresh upper", 8'h72, 4'd3, 16'h0400);
    expectReject("R4 alarm lo upper", 8'h78, 4'd3, 16'h8000);
  endtask

  task automatic tAccess();
    expectReject("R5 ro id", 8'h00, 4'd3, 16'h1234);
    expectReject("R5 ro status", 8'h1C, 4'd2, 16'h0001);
    expectReject("R5 upper half", 8'h11, 4'd2, 16'h0001);
    expectReject("R5 undefined", 8'h30, 4'd2, 16'h0001);
  endtask

  task automatic tCommand();
    expectAccept("R8 cmd ok", 8'h23, 4'd2, 16'h0055, 16'h0055, 1'b0);
    checkEq("R8 cmd stored", cmdLast, 8'h55);
    expectReject("R8 bad opcode", 8'h23, 4'd2, 16'h0012);
    checkEq("R8 cmd kept after bad opcode", cmdLast, 8'h55);
    expectReject("R8 cmd two bytes", 8'h23, 4'd3, 16'h0033);
    checkEq("R8 cmd kept after long write", cmdLast, 8'h55);
    expectAccept("R8 cmd top opcode", 8'h23, 4'd2, 16'h0099, 16'h0099, 1'b0);
    checkEq("R8 cmd updated", cmdLast, 8'h99);
  endtask

  task automatic tReads();
    rd(8'h10, 4'd1);
    checkEq("R9 wide idx1 legal", {ifErr, alertFault}, 2'b00);
    rd(8'h10, 4'd2);
    checkEq("R9 wide idx2 fault", {ifErr, alertFault}, 2'b11);
    clearFaults();
    rd(8'h19, 4'd0);
    checkEq("R9 narrow idx0 legal", {ifErr, alertFault}, 2'b00);
    rd(8'h19, 4'd1);
    checkEq("R9 narrow idx1 fault", {ifErr, alertFault}, 2'b11);
    clearFaults();
    rd(8'h23, 4'd0);
    checkEq("R10 read command", {ifErr, alertFault}, 2'b11);
    clearFaults();
    rd(8'h31, 4'd0);
    checkEq("R10 read undefined", {ifErr, alertFault}, 2'b11);
    clearFaults();
  endtask

  task automatic tClear();
    wr(8'h30, 4'd2, 16'h0000);
    checkEq("R11 setup fault", {ifErr, alertFault}, 2'b11);
    wr(8'h1E, 4'd2, 16'h0002);
    checkEq("R11 wrong bit keeps ifErr", {resAccept, ifErr, alertFault}, 3'b111);
    wr(8'h10, 4'd3, 16'h0100);
    checkEq("R11 wrong bit keeps alert", {resAccept, ifErr, alertFault}, 3'b111);
    wr(8'h1E, 4'd2, 16'h0001);
    checkEq("R11 ifErr cleared alone", {ifErr, alertFault}, 2'b01);
    wr(8'h10, 4'd3, 16'h0200);
    checkEq("R11 alert cleared", {ifErr, alertFault}, 2'b00);
    @(negedge clk);
    txnDone = 1'b1; txnAddr = 8'h1E; txnLen = 4'd2; txnData = 16'h0001;
    rdValid = 1'b1; rdAddr = 8'h19; rdIndex = 4'd3;
    @(negedge clk);
    txnDone = 1'b0; rdValid = 1'b0;
    checkEq("R11 set beats clear", {ifErr, alertFault}, 2'b11);
    clearFaults();
  endtask

  initial begin
    rstN = 1'b0; txnDone = 1'b0; txnAddr = '0; txnLen = '0; txnData = '0;
    rdValid = 1'b0; rdAddr = '0; rdIndex = '0;
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tPointer();
    tAccepts();
    tWidth();
    tReserved();
    tAccess();
    tCommand();
    tReads();
    tClear();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #2000000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule